// File: doc/BRIEF.md
# SMBus Control Register Slave

This block is a two-wire serial slave that exposes six 8-bit control registers to a host. It answers at the 7-bit device address 0x6B, which is 0xD6 with the write bit and 0xD7 with the read bit. It supports four transaction types: byte write, byte read, block write and block read. Bit 7 of the command code selects the mode. When it is 1, the transfer is a single-byte access to the register index in bits 6:0. When it is 0, the transfer is a block access that starts at that index and auto-increments.

The block oversamples SCL and SDA with its own system clock. Each line passes through a two-flop synchronizer and a run-length glitch filter. SDA is driven as an open-drain enable. The register contents drive parallel outputs: six output-enable bits, an amplitude-source select and a 3-bit amplitude code.

Top module: `smb_reg_slave`

## Requirements
- R1: After reset the registers hold 0x00, 0x15, 0xE0, 0x08, 0x06 and 0xD8 at indices 0 to 5, and SDA is released.
- R2: Only the address byte 0xD6 (write) or 0xD7 (read) is acknowledged. Any other address is not acknowledged, and the rest of that transaction changes no register.
- R3: A byte write with command 1xxxxxxx writes the single data byte to register index cmd[6:0].
- R4: A byte read (write command 1xxxxxxx, repeated start, read address) returns that register MSB first.
- R5: A block write with command 0xxxxxxx, followed by a count byte N, writes the next N data bytes to consecutive registers from cmd[6:0]. Data bytes beyond N are acknowledged but not written.
- R6: A block write ended by a stop after any whole byte keeps every data byte that completed before the stop, and writes nothing else.
- R7: A block read with command 0xxxxxxx first returns the contents of register 4 as the byte count. It then returns the registers in ascending order from cmd[6:0] for as long as the master acknowledges.
- R8: A register index of 6 or above reads as 0x00, and writes to it change no register and no output.
- R9: out_en_o[0..2] come from register 1 bits 4, 2 and 0. out_en_o[3..5] come from register 2 bits 7, 6 and 5. A 1 enables the output.
- R10: amp_sel_o is register 5 bit 7 (0 = default amplitude, 1 = use the code). amp_code_o is register 5 bits 6:4, where 0 to 7 encodes 300 mV to 1000 mV in 100 mV steps.
- R11: The slave pulls SDA low during the ninth clock of every accepted address, command, count and data byte. It keeps SDA steady while SCL is high, and releases SDA at a stop.
- R12: A pulse on SCL or SDA shorter than FILT_LEN system clocks has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open-drain enable) |
| out_en_o | output | 6 | Per-output enable bits |
| amp_sel_o | output | 1 | Amplitude source select |
| amp_code_o | output | 3 | Amplitude code |

## Verification
The bench builds the block with FILT_LEN = 4 and six registers. It uses a bit quarter-period of 12 system clocks, which keeps the synchronizer and filter delays inside each SCL phase. At those values, a 2-clock SCL dip in the middle of a data bit falls short of the filter threshold. Command indices 6 and 127 reach the out-of-range read and write path. Rewriting register 4 to 2 shortens the block read the slave reports.

// File: rtl/smb_reg_pkg.sv
package smb_reg_pkg;
  localparam int unsigned NREG      = 6;
  localparam logic [6:0]  DEV_ADDR7 = 7'h6B;
  localparam int unsigned IDX_EN_A  = 1;
  localparam int unsigned IDX_EN_B  = 2;
  localparam int unsigned IDX_CNT   = 4;
  localparam int unsigned IDX_AMP   = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_RX_ACK, ST_TX} xfer_st_e;
  typedef enum logic [1:0] {PH_ADDR, PH_CMD, PH_CNT, PH_DATA} xfer_ph_e;

  function automatic logic [7:0] reg_rst_val(int unsigned idx);
    case (idx)
      1:       return 8'h15;
      2:       return 8'hE0;
      3:       return 8'h08;
      4:       return 8'h06;
      5:       return 8'hD8;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic sync_o,
  output logic filt_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic          meta_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b1;
      sync_o <= 1'b1;
      filt_o <= 1'b1;
      run_q  <= '0;
    end else begin
      meta_q <= raw_i;
      sync_o <= meta_q;
      if (sync_o != filt_o) begin
        if (run_q == CW'(FILT_LEN - 1)) begin
          filt_o <= sync_o;
          run_q  <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end
endmodule

// File: rtl/smb_bus_cond.sv
module smb_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // data edges only count as conditions while the clock stays high
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/smb_reg_file.sv
module smb_reg_file import smb_reg_pkg::*; #(
  parameter int unsigned N = NREG
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_idx_i,
  input  logic [7:0] wr_data_i,
  input  logic [7:0] rd_idx_i,
  output logic [7:0] rd_data_o,
  output logic [7:0] cnt_o,
  output logic [5:0] out_en_o,
  output logic       amp_sel_o,
  output logic [2:0] amp_code_o
);
  localparam int unsigned IW = $clog2(N);

  logic [7:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs[g] <= reg_rst_val(g);
      else if (wr_en_i && (wr_idx_i == 8'(g)))
        regs[g] <= wr_data_i;
    end
  end

  assign rd_data_o  = (rd_idx_i < 8'(N)) ? regs[rd_idx_i[IW-1:0]] : 8'h00;
  assign cnt_o      = regs[IDX_CNT];
  assign out_en_o   = {regs[IDX_EN_B][5], regs[IDX_EN_B][6], regs[IDX_EN_B][7],
                       regs[IDX_EN_A][0], regs[IDX_EN_A][2], regs[IDX_EN_A][4]};
  assign amp_sel_o  = regs[IDX_AMP][7];
  assign amp_code_o = regs[IDX_AMP][6:4];
endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm import smb_reg_pkg::*; #(
  parameter logic [6:0] DEV_ADDR = DEV_ADDR7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       sda_i,
  input  logic [7:0] rd_data_i,
  input  logic [7:0] cnt_i,
  output logic       sda_oe_o,
  output logic       wr_en_o,
  output logic [7:0] wr_idx_o,
  output logic [7:0] wr_data_o,
  output logic [7:0] rd_idx_o
);
  xfer_st_e   st_q;
  xfer_ph_e   ph_q;
  logic [7:0] sh_q, ptr_q, wcnt_q;
  logic [3:0] bit_q;
  logic       blk_q, rd_req_q, tx_first_q, m_ack_q, tx_ack_q;

  logic [7:0] ptr_inc, tx_byte;
  logic       tx_cnt;

  assign ptr_inc  = (ptr_q == 8'hFF) ? ptr_q : ptr_q + 8'd1;
  assign tx_cnt   = blk_q & tx_first_q;   // first byte of a block read is the count
  assign tx_byte  = tx_cnt ? cnt_i : rd_data_i;
  assign rd_idx_o = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      ph_q       <= PH_ADDR;
      sh_q       <= '0;
      ptr_q      <= '0;
      wcnt_q     <= '0;
      bit_q      <= '0;
      blk_q      <= 1'b0;
      rd_req_q   <= 1'b0;
      tx_first_q <= 1'b0;
      m_ack_q    <= 1'b0;
      tx_ack_q   <= 1'b0;
      sda_oe_o   <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_idx_o   <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        st_q     <= ST_RX;
        ph_q     <= PH_ADDR;
        bit_q    <= '0;
        rd_req_q <= 1'b0;
        tx_ack_q <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        st_q     <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        case (st_q)
          ST_RX: begin
            if (scl_rise_i && bit_q != 4'd8) begin
              sh_q  <= {sh_q[6:0], sda_i};
              bit_q <= bit_q + 4'd1;
            end else if (scl_fall_i && bit_q == 4'd8) begin
              st_q     <= ST_RX_ACK;
              sda_oe_o <= 1'b1;
              case (ph_q)
                PH_ADDR: begin
                  if (sh_q[7:1] == DEV_ADDR) begin
                    rd_req_q   <= sh_q[0];
                    tx_first_q <= 1'b1;
                    ph_q       <= PH_CMD;
                  end else begin
                    st_q     <= ST_IDLE;
                    sda_oe_o <= 1'b0;
                  end
                end
                PH_CMD: begin
                  blk_q  <= ~sh_q[7];
                  ptr_q  <= {1'b0, sh_q[6:0]};
                  wcnt_q <= sh_q[7] ? 8'd1 : 8'd0;
                  ph_q   <= sh_q[7] ? PH_DATA : PH_CNT;
                end
                PH_CNT: begin
                  wcnt_q <= sh_q;
                  ph_q   <= PH_DATA;
                end
                default: begin
                  if (wcnt_q != 8'd0) begin
                    wr_en_o   <= 1'b1;
                    wr_idx_o  <= ptr_q;
                    wr_data_o <= sh_q;
                    wcnt_q    <= wcnt_q - 8'd1;
                    ptr_q     <= ptr_inc;
                  end
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall_i) begin
              bit_q <= '0;
              if (rd_req_q) begin
                st_q       <= ST_TX;
                sh_q       <= tx_byte;
                sda_oe_o   <= ~tx_byte[7];
                tx_first_q <= 1'b0;
                if (!tx_cnt) ptr_q <= ptr_inc;
              end else begin
                st_q     <= ST_RX;
                sda_oe_o <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (!tx_ack_q) begin
              if (scl_fall_i) begin
                if (bit_q == 4'd7) begin
                  sda_oe_o <= 1'b0;
                  tx_ack_q <= 1'b1;
                end else begin
                  sh_q     <= {sh_q[6:0], 1'b0};
                  sda_oe_o <= ~sh_q[6];
                  bit_q    <= bit_q + 4'd1;
                end
              end
            end else if (scl_rise_i) begin
              m_ack_q <= ~sda_i;
            end else if (scl_fall_i) begin
              tx_ack_q <= 1'b0;
              if (m_ack_q) begin
                bit_q      <= '0;
                sh_q       <= tx_byte;
                sda_oe_o   <= ~tx_byte[7];
                tx_first_q <= 1'b0;
                if (!tx_cnt) ptr_q <= ptr_inc;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave import smb_reg_pkg::*; #(
  parameter int unsigned FILT_LEN = 4,
  parameter logic [6:0]  DEV_ADDR = DEV_ADDR7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic [5:0] out_en_o,
  output logic       amp_sel_o,
  output logic [2:0] amp_code_o
);
  localparam int unsigned NLINE = 2;

  logic [NLINE-1:0] line_raw, line_s, line_f;
  logic scl_s, scl_f, sda_f;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic       wr_en;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data, cnt_val;

  assign line_raw = {sda_i, scl_i};

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    smb_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (line_raw[l]),
      .sync_o(line_s[l]),
      .filt_o(line_f[l])
    );
  end

  assign scl_s = line_s[0];
  assign scl_f = line_f[0];
  assign sda_f = line_f[1];

  smb_bus_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_f),
    .sda_i     (sda_f),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  smb_xfer_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .sda_i     (sda_f),
    .rd_data_i (rd_data),
    .cnt_i     (cnt_val),
    .sda_oe_o  (sda_oe_o),
    .wr_en_o   (wr_en),
    .wr_idx_o  (wr_idx),
    .wr_data_o (wr_data),
    .rd_idx_o  (rd_idx)
  );

  smb_reg_file #(.N(NREG)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data),
    .cnt_o     (cnt_val),
    .out_en_o  (out_en_o),
    .amp_sel_o (amp_sel_o),
    .amp_code_o(amp_code_o)
  );
endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk #(
  parameter int unsigned N = 6
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_s,
  input logic       scl_f,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_oe_o,
  input logic       wr_en,
  input logic [7:0] wr_idx,
  input logic [5:0] out_en_o,
  input logic       amp_sel_o,
  input logic [2:0] amp_code_o
);
  AST_OOR_WRITE_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_idx >= 8'(N)) |=> ($stable(out_en_o) && $stable(amp_sel_o) && $stable(amp_code_o))); // R8

  AST_EN_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_en_o) |-> $past(wr_en)); // R9

  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_f && $past(scl_f) && !$past(stop_det) && !$past(start_det)) |-> $stable(sda_oe_o)); // R11

  AST_STOP_RELEASES_SDA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o); // R11

  AST_FILTER_MIN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scl_f) |-> ($past(scl_s, 1) == scl_f && $past(scl_s, 2) == scl_f)); // R12
endmodule

bind smb_reg_slave smb_reg_slave_chk #(.N(smb_reg_pkg::NREG)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_s     (scl_s),
  .scl_f     (scl_f),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe_o  (sda_oe_o),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .out_en_o  (out_en_o),
  .amp_sel_o (amp_sel_o),
  .amp_code_o(amp_code_o)
);

// File: tb/smb_reg_slave_bench.sv
module smb_reg_slave_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  Q          = 12;
  localparam int  WDOG_LIMIT = 180000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_bus;
  logic sda_oe, amp_sel;
  logic [5:0] out_en;
  logic [2:0] amp_code;
  int n_chk = 0, n_fail = 0, cyc = 0;

  assign sda_bus = m_sda & ~sda_oe;
  always #(CLK_PERIOD/2) clk = ~clk;

  smb_reg_slave u_smb_reg_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .out_en_o(out_en), .amp_sel_o(amp_sel), .amp_code_o(amp_code));

  typedef struct packed { logic [7:0] cmd; logic [7:0] wdat; logic [7:0] exp; } vec_t;
  localparam vec_t VECS [5] = '{
    '{8'h80, 8'h5A, 8'h5A},   // R3 R4 reg0
    '{8'h83, 8'h3C, 8'h3C},   // R3 R4 reg3
    '{8'h86, 8'hFF, 8'h00},   // R8 idx 6
    '{8'hFF, 8'h12, 8'h00},   // R8 idx 127
    '{8'h85, 8'hA7, 8'hA7}    // R10 reg5
  };

  task automatic wt(int n); repeat (n) @(negedge clk); endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic m_start(); m_sda = 1; wt(2*Q); m_scl = 1; wt(Q); m_sda = 0; wt(Q); m_scl = 0; wt(Q); endtask
  task automatic m_stop();  m_sda = 0; wt(Q); m_scl = 1; wt(Q); m_sda = 1; wt(2*Q); endtask

  task automatic wr_bit(logic b, bit glitch);
    wt(Q); m_sda = b; wt(Q); m_scl = 1;
    if (glitch) begin wt(Q); m_scl = 0; wt(2); m_scl = 1; wt(Q-2); end
    else wt(2*Q);
    m_scl = 0;
  endtask

  task automatic rd_bit(output logic b);
    m_sda = 1; wt(2*Q); m_scl = 1; wt(Q); b = sda_bus; wt(Q); m_scl = 0;
  endtask

  // send a byte, check the acknowledge level (0 = ack)
  task automatic tx_byte(logic [7:0] d, logic exp_ack, int glitch_bit = -1);
    logic a;
    for (int i = 7; i >= 0; i--) wr_bit(d[i], i == glitch_bit);
    rd_bit(a);
    check("R11 ack", {7'd0, a}, {7'd0, exp_ack});
  endtask

  task automatic rx_byte(output logic [7:0] d, input logic nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin rd_bit(b); d[i] = b; end
    wr_bit(nack, 1'b0);
  endtask

  task automatic byte_wr(logic [7:0] cmd, logic [7:0] dat, int glitch_bit = -1);
    m_start(); tx_byte(8'hD6, 0); tx_byte(cmd, 0); tx_byte(dat, 0, glitch_bit); m_stop();
  endtask

  task automatic byte_rd(logic [7:0] cmd, output logic [7:0] d);
    m_start(); tx_byte(8'hD6, 0); tx_byte(cmd, 0);
    m_start(); tx_byte(8'hD7, 0); rx_byte(d, 1'b1); m_stop();
  endtask

  task automatic blk_rd_check(logic [7:0] cmd, int n, logic [7:0] e0, e1, e2, e3, e4, e5, e6);
    logic [7:0] exp [7];
    logic [7:0] d;
    exp = '{e0, e1, e2, e3, e4, e5, e6};
    m_start(); tx_byte(8'hD6, 0); tx_byte(cmd, 0);
    m_start(); tx_byte(8'hD7, 0);
    for (int i = 0; i < n; i++) begin
      rx_byte(d, i == n - 1);
      check("R7 block read", d, exp[i]);
    end
    m_stop();
  endtask

  initial begin
    wait (cyc >= WDOG_LIMIT);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG_LIMIT);
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    logic [7:0] d;
    wt(5); rst_n = 1; wt(5);

    // R1 R9 R10 reset state at the ports
    check("R1 sda released", {7'd0, sda_oe}, 8'h00);
    check("R9 reset enables", {2'd0, out_en}, 8'h3F);
    check("R10 reset amp sel", {7'd0, amp_sel}, 8'h01);
    check("R10 reset amp code", {5'd0, amp_code}, 8'h05);

    // R1 R7 block read of all reset values, count from register 4
    blk_rd_check(8'h00, 7, 8'h06, 8'h00, 8'h15, 8'hE0, 8'h08, 8'h06, 8'hD8);

    // R2 wrong address: no ack, disabling write does not land
    m_start(); tx_byte(8'hA0, 1); tx_byte(8'h81, 1); tx_byte(8'h00, 1); m_stop();
    check("R2 foreign address ignored", {2'd0, out_en}, 8'h3F);

    // R3 R4 R8 vector table
    foreach (VECS[k]) begin
      byte_wr(VECS[k].cmd, VECS[k].wdat);
      byte_rd(VECS[k].cmd, d);
      check("R3 R4 R8 write/read", d, VECS[k].exp);
    end
    check("R10 amp sel after write", {7'd0, amp_sel}, 8'h01);
    check("R10 amp code after write", {5'd0, amp_code}, 8'h02);
    byte_wr(8'h85, 8'h50);
    check("R10 default amp sel", {7'd0, amp_sel}, 8'h00);
    check("R10 amp code", {5'd0, amp_code}, 8'h05);

    // R9 bit mapping
    byte_wr(8'h81, 8'h04);
    byte_wr(8'h82, 8'h40);
    check("R9 enable mapping", {2'd0, out_en}, 8'h12);

    // R5 block write of 2, third byte beyond count
    m_start(); tx_byte(8'hD6, 0); tx_byte(8'h01, 0); tx_byte(8'h02, 0);
    tx_byte(8'hFF, 0); tx_byte(8'hFF, 0); tx_byte(8'h00, 0); m_stop();
    check("R5 block write enables", {2'd0, out_en}, 8'h3F);
    byte_rd(8'h83, d); check("R5 byte beyond count not written", d, 8'h3C);

    // R6 block write of 3 stopped after one data byte
    m_start(); tx_byte(8'hD6, 0); tx_byte(8'h03, 0); tx_byte(8'h03, 0);
    tx_byte(8'h11, 0); m_stop();
    byte_rd(8'h83, d); check("R6 completed byte kept", d, 8'h11);
    byte_rd(8'h84, d); check("R6 next reg untouched", d, 8'h06);
    byte_rd(8'h85, d); check("R6 last reg untouched", d, 8'h50);

    // R7 block read length follows register 4
    byte_wr(8'h84, 8'h02);
    blk_rd_check(8'h02, 3, 8'h02, 8'hFF, 8'h11, 8'h00, 8'h00, 8'h00, 8'h00);

    // R12 short SCL dip inside data bit 3
    byte_wr(8'h80, 8'hC3, 3);
    byte_rd(8'h80, d); check("R12 glitch ignored", d, 8'hC3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule